// File: doc/BRIEF.md
# Keyed-Command Watchdog Timer

This block is a watchdog down-counter driven through a small register bus. Software steers it by writing 16-bit command words to a control register. Each recognised word does one thing: halt the count, let it run, acknowledge the timeout flag, open or close the counter for writes, or reload the counter with its largest value. Any other value written to the control register has no effect. The counter is 20 bits wide and drops by one on each cycle that the slow tick enable is high while the timer is running. Software can load and read only the upper 16 bits of the count, so a loaded value always has a zero low nibble.

When the count runs out, the block sets a sticky timeout flag and stops at zero. It also sends a single-cycle reset request on each reset output that is enabled. A separate enable register chooses which outputs fire. This register takes masked writes, so any one enable bit can be changed without a read-modify-write. A quick restart is done by opening the counter, writing a value of 1, closing it and sending the run command: the timeout then arrives on the sixteenth tick.

Top module: `keyedWatchdog`

## Requirements
- R1: After reset the timer is halted and the counter is closed for writes. The count is 0xFFFF0 (so a counter read returns 0xFFFF), the timeout flag is low, both reset outputs are low and the enable register reads 0.
- R2: The control register is at offset 0x0, the counter at 0x4 and the enable register at 0x8. A read of the control register or of any unmapped offset returns 0.
- R3: Command 0x4A4B starts the count and command 0x3877 halts it. The count drops by exactly one on each tick-enable cycle while running and holds while halted.
- R4: Command 0xAB00 opens the counter for writes and command 0xAB01 closes it. A counter write made while the counter is closed leaves the count unchanged.
- R5: A counter write made while the counter is open places write data [15:0] in count[19:4] and clears count[3:0].
- R6: A counter read returns count[19:4] in data bits [15:0], with bits [31:16] zero.
- R7: Command 0xDEAF reloads the count to 0xFFFF0, whether the counter is open or closed.
- R8: A control write whose bits [15:0] match none of the six command words changes neither the run state, the lock state nor the count.
- R9: On a running tick with a count of 1 or 0, the flag rises at that clock edge, the count becomes 0 and stays there, and the timer halts. Loading 1 and then running gives a timeout on the sixteenth tick.
- R10: The timeout flag stays set until command 0x7482 is written. Running again while the flag is still set leaves it set.
- R11: The enable register takes masked writes: write bit 16+i lets write bit i update enable bit i. Bits [15:0] read back.
- R12: At a timeout, reset output A pulses high for one cycle if enable bit 1 is set, and reset output B does the same if enable bit 4 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tickEn | input | 1 | Slow count enable, one cycle per tick |
| busWrEn | input | 1 | Write strobe for the register bus |
| busAddr | input | 4 | Byte offset for reads and writes |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data for busAddr (combinational) |
| timeoutFlag | output | 1 | Sticky timeout flag |
| rstReqA | output | 1 | Reset request A, one-cycle pulse |
| rstReqB | output | 1 | Reset request B, one-cycle pulse |

## Verification
The assertions check on every cycle that the count never rises except through a load, that a user load leaves a zero low nibble, that a full reload gives the maximum, and that an expiry halts the timer at zero with the flag raised. They also check that the flag and the lock stay put unless the matching command arrives, and that the reset requests last only one cycle. Only the directed scenarios can show the effect of each command word at the ports. The same goes for the exact tick on which a short load expires, which enable bit drives which output, and what the masked enable writes leave in place.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  // Command words accepted by the control register
  localparam logic [15:0] CMD_HALT = 16'h3877;
  localparam logic [15:0] CMD_GO   = 16'h4A4B;
  localparam logic [15:0] CMD_ACK  = 16'h7482;
  localparam logic [15:0] CMD_OPEN = 16'hAB00;
  localparam logic [15:0] CMD_SHUT = 16'hAB01;
  localparam logic [15:0] CMD_FULL = 16'hDEAF;

  // Strobes from the control path to the counter datapath
  typedef struct packed {
    logic loadFull;
    logic loadUser;
    logic clrFlag;
    logic run;
  } dpStrobe_t;
endpackage

// File: rtl/wdog_dp.sv
module wdog_dp
  import wdog_pkg::*;
#(
  parameter int CNT_W  = 20,
  parameter int LOAD_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  dpStrobe_t         strobe,
  input  logic [LOAD_W-1:0] loadData,
  output logic [CNT_W-1:0]  count,
  output logic              flag,
  output logic              expire
);
  localparam int LSB_W = CNT_W - LOAD_W;
  localparam logic [CNT_W-1:0] FULL_CNT = {{LOAD_W{1'b1}}, {LSB_W{1'b0}}};

  logic loading;
  logic nearZero;

  assign loading  = strobe.loadFull | strobe.loadUser;
  assign nearZero = (count[CNT_W-1:1] == '0);
  assign expire   = strobe.run & tickEn & nearZero & ~loading;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count <= FULL_CNT;
    end else if (strobe.loadUser) begin
      count <= {loadData, {LSB_W{1'b0}}};
    end else if (strobe.loadFull) begin
      count <= FULL_CNT;
    end else if (expire) begin
      count <= '0;
    end else if (strobe.run && tickEn) begin
      count <= count - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flag <= 1'b0;
    end else if (expire) begin
      flag <= 1'b1;
    end else if (strobe.clrFlag) begin
      flag <= 1'b0;
    end
  end

  // R3
  cnt_no_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    !loading |=> count <= $past(count));
  // R5
  user_nibble_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadUser |=> count[LSB_W-1:0] == '0);
  // R7
  full_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.loadFull && !strobe.loadUser) |=> count == FULL_CNT);
  // R9
  expire_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    expire |=> (count == '0) && flag);
  // R10
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (flag && !strobe.clrFlag) |=> flag);
endmodule

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
  import wdog_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  parameter int LOAD_W = 16,
  parameter int EN_W   = 16,
  parameter int EN_A_BIT = 1,
  parameter int EN_B_BIT = 4,
  parameter logic [ADDR_W-1:0] CTRL_OFS = 'h0,
  parameter logic [ADDR_W-1:0] CNT_OFS  = 'h4,
  parameter logic [ADDR_W-1:0] EN_OFS   = 'h8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  input  logic              expire,
  output dpStrobe_t         strobe,
  output logic [LOAD_W-1:0] loadData,
  output logic [EN_W-1:0]   rstEn,
  output logic              rstReqA,
  output logic              rstReqB
);
  logic        wrCtrl, wrCnt, wrEnReg;
  logic [15:0] cmdWord;
  logic        running, locked;
  logic        isHalt, isGo, isAck, isOpen, isShut, isFull;

  assign wrCtrl  = busWrEn && (busAddr == CTRL_OFS);
  assign wrCnt   = busWrEn && (busAddr == CNT_OFS);
  assign wrEnReg = busWrEn && (busAddr == EN_OFS);
  assign cmdWord = busWrData[15:0];

  assign isHalt = wrCtrl && (cmdWord == CMD_HALT);
  assign isGo   = wrCtrl && (cmdWord == CMD_GO);
  assign isAck  = wrCtrl && (cmdWord == CMD_ACK);
  assign isOpen = wrCtrl && (cmdWord == CMD_OPEN);
  assign isShut = wrCtrl && (cmdWord == CMD_SHUT);
  assign isFull = wrCtrl && (cmdWord == CMD_FULL);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running <= 1'b0;
    end else if (expire || isHalt) begin
      running <= 1'b0;
    end else if (isGo) begin
      running <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      locked <= 1'b1;
    end else if (isOpen) begin
      locked <= 1'b0;
    end else if (isShut) begin
      locked <= 1'b1;
    end
  end

  always_comb begin
    strobe.loadFull = isFull;
    strobe.loadUser = wrCnt && !locked;
    strobe.clrFlag  = isAck;
    strobe.run      = running;
  end
  assign loadData = busWrData[LOAD_W-1:0];

  // Masked enable register: upper half gates each lower bit
  for (genvar i = 0; i < EN_W; i++) begin : g_en
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        rstEn[i] <= 1'b0;
      end else if (wrEnReg && busWrData[EN_W+i]) begin
        rstEn[i] <= busWrData[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rstReqA <= 1'b0;
      rstReqB <= 1'b0;
    end else begin
      rstReqA <= expire && rstEn[EN_A_BIT];
      rstReqB <= expire && rstEn[EN_B_BIT];
    end
  end

  // R9
  halt_on_expire_chk: assert property (@(posedge clk) disable iff (!rstN)
    expire |=> !running);
  // R4
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (locked && !isOpen) |=> locked);
  // R12
  req_a_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    rstReqA |=> !rstReqA);
  // R12
  req_b_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    rstReqB |=> !rstReqB);
endmodule

// File: rtl/keyedWatchdog.sv
module keyedWatchdog
  import wdog_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 32,
  parameter int CNT_W    = 20,
  parameter int LOAD_W   = 16,
  parameter int EN_W     = 16,
  parameter int EN_A_BIT = 1,
  parameter int EN_B_BIT = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  output logic              timeoutFlag,
  output logic              rstReqA,
  output logic              rstReqB
);
  localparam int LSB_W = CNT_W - LOAD_W;
  localparam logic [ADDR_W-1:0] CTRL_OFS = 'h0;
  localparam logic [ADDR_W-1:0] CNT_OFS  = 'h4;
  localparam logic [ADDR_W-1:0] EN_OFS   = 'h8;

  dpStrobe_t         strobe;
  logic [LOAD_W-1:0] loadData;
  logic [CNT_W-1:0]  count;
  logic [EN_W-1:0]   rstEn;
  logic              expire;

  wdog_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LOAD_W(LOAD_W), .EN_W(EN_W),
    .EN_A_BIT(EN_A_BIT), .EN_B_BIT(EN_B_BIT),
    .CTRL_OFS(CTRL_OFS), .CNT_OFS(CNT_OFS), .EN_OFS(EN_OFS)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWrData(busWrData), .expire(expire), .strobe(strobe),
    .loadData(loadData), .rstEn(rstEn), .rstReqA(rstReqA), .rstReqB(rstReqB)
  );

  wdog_dp #(.CNT_W(CNT_W), .LOAD_W(LOAD_W)) uDp (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .strobe(strobe),
    .loadData(loadData), .count(count), .flag(timeoutFlag), .expire(expire)
  );

  always_comb begin
    busRdData = '0;
    if (busAddr == CNT_OFS) begin
      busRdData = {{(DATA_W-LOAD_W){1'b0}}, count[CNT_W-1:LSB_W]};
    end else if (busAddr == EN_OFS) begin
      busRdData = {{(DATA_W-EN_W){1'b0}}, rstEn};
    end
  end
endmodule

// File: tb/sim_keyedWatchdog.sv
module sim_keyedWatchdog;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tickEn = 1'b0;
  logic        busWrEn = 1'b0;
  logic [3:0]  busAddr = '0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic        timeoutFlag, rstReqA, rstReqB;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  keyedWatchdog u0 (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .busWrEn(busWrEn),
    .busAddr(busAddr), .busWrData(busWrData), .busRdData(busRdData),
    .timeoutFlag(timeoutFlag), .rstReqA(rstReqA), .rstReqB(rstReqB)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; tickEn = 1'b0; busWrEn = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic wrReg(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    busWrEn = 1'b1; busAddr = a; busWrData = d;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic rdReg(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a;
    #1 d = busRdData;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tickEn = 1'b1;
    end
    @(negedge clk);
    tickEn = 1'b0;
  endtask

  task automatic expectRd(input logic [3:0] a, input logic [31:0] e, input string tag);
    logic [31:0] d;
    rdReg(a, d);
    chk(d == e, tag, d, e);
  endtask

  task automatic testReset();
    doReset();
    chk(timeoutFlag == 1'b0, "R1 flag", {31'b0, timeoutFlag}, 0);
    chk(!rstReqA && !rstReqB, "R1 reqs", {30'b0, rstReqA, rstReqB}, 0);
    expectRd(4'h4, 32'h0000_FFFF, "R1 count max");
    expectRd(4'h8, 32'h0, "R1 enables off");
    ticks(4);
    expectRd(4'h4, 32'h0000_FFFF, "R1 halted");
    wrReg(4'h4, 32'h0000_1234);
    expectRd(4'h4, 32'h0000_FFFF, "R1 locked");
  endtask

  task automatic testMap();
    doReset();
    expectRd(4'h0, 32'h0, "R2 ctrl reads zero");
    expectRd(4'hC, 32'h0, "R2 unmapped zero");
    wrReg(4'h0, 32'h0000_AB00);
    wrReg(4'h4, 32'hFFFF_0042);
    expectRd(4'h4, 32'h0000_0042, "R6 upper half zero");
  endtask

  task automatic testRunHalt();
    doReset();
    wrReg(4'h0, 32'h0000_AB00);
    wrReg(4'h4, 32'h0000_0003);
    wrReg(4'h0, 32'h0000_4A4B);
    ticks(16);
    expectRd(4'h4, 32'h2, "R3 running 16 ticks");
    wrReg(4'h0, 32'h0000_3877);
    ticks(32);
    expectRd(4'h4, 32'h2, "R3 halted holds");
    wrReg(4'h0, 32'h0000_4A4B);
    ticks(15);
    expectRd(4'h4, 32'h1, "R3 one per tick");
    ticks(1);
    expectRd(4'h4, 32'h1, "R3 sixteenth tick");
    chk(timeoutFlag == 1'b0, "R3 no timeout", {31'b0, timeoutFlag}, 0);
  endtask

  task automatic testLock();
    doReset();
    wrReg(4'h0, 32'h0000_AB00);
    wrReg(4'h4, 32'h0000_1234);
    expectRd(4'h4, 32'h1234, "R4 open write");
    wrReg(4'h0, 32'h0000_AB01);
    wrReg(4'h4, 32'h0000_5678);
    expectRd(4'h4, 32'h1234, "R4 closed write ignored");
    wrReg(4'h0, 32'h0000_DEAF);
    expectRd(4'h4, 32'hFFFF, "R7 full reload while closed");
  endtask

  task automatic testNibble();
    doReset();
    wrReg(4'h0, 32'h0000_AB00);
    wrReg(4'h4, 32'h0000_0002);
    wrReg(4'h0, 32'h0000_4A4B);
    ticks(1);
    wrReg(4'h0, 32'h0000_3877);
    expectRd(4'h4, 32'h1, "R5 low nibble cleared");
  endtask

  task automatic testBogus();
    doReset();
    wrReg(4'h0, 32'h0000_AB02);
    wrReg(4'h0, 32'h0000_1234);
    wrReg(4'h4, 32'h0000_0005);
    expectRd(4'h4, 32'hFFFF, "R8 bogus word no unlock");
    wrReg(4'h0, 32'h0000_AB00);
    wrReg(4'h4, 32'h0000_0005);
    wrReg(4'h0, 32'h0000_4A4B);
    wrReg(4'h0, 32'h0000_3878);
    wrReg(4'h0, 32'h0000_DEAE);
    ticks(16);
    expectRd(4'h4, 32'h4, "R8 bogus word no halt or reload");
  endtask

  task automatic testMask();
    doReset();
    wrReg(4'h8, 32'h0000_FFFF);
    expectRd(4'h8, 32'h0, "R11 no mask no change");
    wrReg(4'h8, 32'h0012_FFFF);
    expectRd(4'h8, 32'h0012, "R11 masked set");
    wrReg(4'h8, 32'h0010_0000);
    expectRd(4'h8, 32'h0002, "R11 masked clear one bit");
  endtask

  task automatic shortExpire(input logic [31:0] en);
    doReset();
    wrReg(4'h8, en);
    wrReg(4'h0, 32'h0000_AB00);
    wrReg(4'h4, 32'h0000_0001);
    wrReg(4'h0, 32'h0000_AB01);
    wrReg(4'h0, 32'h0000_4A4B);
    ticks(15);
    chk(timeoutFlag == 1'b0, "R9 no flag before 16th tick", {31'b0, timeoutFlag}, 0);
  endtask

  task automatic testExpire();
    shortExpire(32'h0012_0012);
    ticks(1);
    #1;
    chk(timeoutFlag == 1'b1, "R9 flag on 16th tick", {31'b0, timeoutFlag}, 1);
    chk(rstReqA == 1'b1, "R12 req A pulse", {31'b0, rstReqA}, 1);
    chk(rstReqB == 1'b1, "R12 req B pulse", {31'b0, rstReqB}, 1);
    @(negedge clk); #1;
    chk(!rstReqA && !rstReqB, "R12 one cycle", {30'b0, rstReqA, rstReqB}, 0);
    ticks(5);
    expectRd(4'h4, 32'h0, "R9 held at zero");
    wrReg(4'h0, 32'h0000_3877);
    chk(timeoutFlag == 1'b1, "R10 flag survives halt", {31'b0, timeoutFlag}, 1);
    wrReg(4'h0, 32'h0000_4A4B);
    ticks(1);
    chk(timeoutFlag == 1'b1, "R10 rerun with flag set", {31'b0, timeoutFlag}, 1);
    wrReg(4'h0, 32'h0000_7482);
    chk(timeoutFlag == 1'b0, "R10 ack clears", {31'b0, timeoutFlag}, 0);
    ticks(3);
    chk(timeoutFlag == 1'b0, "R9 timer halted after expiry", {31'b0, timeoutFlag}, 0);
  endtask

  task automatic testOnlyA();
    shortExpire(32'h0002_0002);
    ticks(1);
    #1;
    chk(rstReqA == 1'b1, "R12 A enabled fires", {31'b0, rstReqA}, 1);
    chk(rstReqB == 1'b0, "R12 B disabled quiet", {31'b0, rstReqB}, 0);
    shortExpire(32'h0010_0010);
    ticks(1);
    #1;
    chk(rstReqA == 1'b0, "R12 A disabled quiet", {31'b0, rstReqA}, 0);
    chk(rstReqB == 1'b1, "R12 B enabled fires", {31'b0, rstReqB}, 1);
  endtask

  initial begin
    testReset();
    testMap();
    testRunHalt();
    testLock();
    testNibble();
    testBogus();
    testMask();
    testExpire();
    testOnlyA();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule